// File: doc/BRIEF.md
# SPI Slave Sensor Register Reader with Burst Packet

This block is a 16-bit-word SPI slave that lets a host read eight sensor output words. The words arrive on a parallel input from the sensor side. The host reads them in one of two ways. A polled read asks for one register by address and gets its live value on the following word. A burst read sends one command word and then clocks out the whole eight-word packet on the next eight transfers.

The burst packet is not read live. It comes from a snapshot buffer that is reloaded from the sensor inputs, all at once, when a burst completes. The packet returned by one burst therefore comes from a single instant. The snapshot is cleared at reset, so the first burst after reset returns the previous (cleared) contents. Every burst after that returns the snapshot taken at the end of the burst before it.

The serial pins are oversampled by the system clock. Chip select may be pulsed for every word or held low through a whole burst. The burst position is kept while chip select is high, so both framings give the same data.

Top module: `spibr_top`

## Requirements
- R1: After reset, MISO is low, no burst is in progress and the snapshot buffer holds all zeros.
- R2: Transfers are SPI mode 3 (SCLK idles high, MISO changes after a falling edge, MOSI is sampled on a rising edge), MSB first, 16 bits per word. If chip select goes high before the sixteenth rising edge, the partial word is discarded and has no effect.
- R3: A word with bit 15 clear is a polled read of the register whose address is in bits 15:8. Its value comes out on the next word. The address map is: status 0x3C, X rate 0x04, Y rate 0x06, Z rate 0x08, X accel 0x0A, Y accel 0x0C, Z accel 0x0E, temperature 0x18. An unmapped address returns 0x0000.
- R4: The word 0x3E00 starts a burst. The next eight words return, in order, status, X rate, Y rate, Z rate, X accel, Y accel, Z accel and temperature. These are input slots 0 to 7.
- R5: Burst words come from the snapshot buffer. All eight slots are captured together at the end of the eighth burst word. The first burst after reset returns zeros.
- R6: Pulsing chip select between words and holding it low for the whole burst return the same sequence.
- R7: A burst ends only after its eighth data word. Until then every word is taken as a further burst word, whatever its content, even if it is a valid command.
- R8: A polled read returns the live sensor input and leaves the snapshot unchanged.
- R9: The word after the eighth burst word, and the word after any word with bit 15 set, returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| sens_words | input | 8x16 | Sensor words, slot 0 status through slot 7 temperature |

## Verification
The bench builds the block with its default two-stage synchronizers. It clocks SPI at one sixteenth of the system clock, so every serial edge leaves enough margin for the synchronizer latency plus the decode step. With these values, the bench can run both chip-select framings back to back. It can change the sensor inputs between bursts, which shows the snapshot lagging by one burst. It can also cut a burst short and send a polled command where a burst word is expected, which leaves host and slave out of step until the eighth word completes.

// File: rtl/spibr_pkg.sv
package spibr_pkg;
    localparam int WORD_W    = 16;
    localparam int HDR_W     = 8;
    localparam int PKT_WORDS = 8;
    localparam int IDX_W     = $clog2(PKT_WORDS);
    localparam logic [HDR_W-1:0] BURST_HDR = 8'h3E;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HDR_W-1:0]  hdr_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {CMD_NONE, CMD_POLL, CMD_BURST} cmd_e;

    typedef struct packed {
        logic hit;
        idx_t idx;
    } lookup_t;

    // Register address of each packet slot; slot order is the burst order.
    function automatic hdr_t slot_addr(input int k);
        case (k)
            0:       return 8'h3C;
            1:       return 8'h04;
            2:       return 8'h06;
            3:       return 8'h08;
            4:       return 8'h0A;
            5:       return 8'h0C;
            6:       return 8'h0E;
            default: return 8'h18;
        endcase
    endfunction

    function automatic lookup_t find_slot(input hdr_t a);
        lookup_t r;
        r = '0;
        for (int k = 0; k < PKT_WORDS; k++) begin
            if (slot_addr(k) == a) begin
                r.hit = 1'b1;
                r.idx = idx_t'(k);
            end
        end
        return r;
    endfunction

    function automatic cmd_e decode(input hdr_t h);
        if (h[HDR_W-1])      return CMD_NONE;
        if (h == BURST_HDR)  return CMD_BURST;
        return CMD_POLL;
    endfunction
endpackage

// File: rtl/spibr_sync.sv
module spibr_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 3,
    parameter logic [WIDTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) pipe[0] <= INIT;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) pipe[s] <= INIT;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spibr_shift.sv
module spibr_shift
    import spibr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  mosi,
    input  word_t tx_word,
    output logic  miso,
    output logic  word_done,
    output hdr_t  rx_hdr
);
    localparam int CNT_W = $clog2(WORD_W);

    logic             sclk_q;
    logic [CNT_W-1:0] cnt;
    word_t            rx_sh, tx_sh, rx_next;
    logic             rise, fall;

    assign rise    = sclk & ~sclk_q & ~cs_n;
    assign fall    = ~sclk & sclk_q & ~cs_n;
    assign rx_next = {rx_sh[WORD_W-2:0], mosi};
    assign miso    = tx_sh[WORD_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b1;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            word_done <= 1'b0;
            rx_hdr    <= '0;
        end else begin
            sclk_q    <= sclk;
            word_done <= 1'b0;
            if (cs_n) begin
                cnt <= '0;
            end else begin
                if (fall) tx_sh <= (cnt == '0) ? tx_word : {tx_sh[WORD_W-2:0], 1'b0};
                if (rise) begin
                    rx_sh <= rx_next;
                    if (cnt == CNT_W'(WORD_W-1)) begin
                        cnt       <= '0;
                        word_done <= 1'b1;
                        rx_hdr    <= rx_next[WORD_W-1 -: HDR_W];
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end

    p_abort_clears_r2: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (cnt == '0));
    p_done_needs_select_r2: assert property (@(posedge clk) disable iff (rst)
        word_done |-> !$past(cs_n));
endmodule

// File: rtl/spibr_ctrl.sv
module spibr_ctrl
    import spibr_pkg::*;
(
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               word_done,
    input  hdr_t                               rx_hdr,
    input  logic [PKT_WORDS-1:0][WORD_W-1:0]   sens,
    output word_t                              tx_word
);
    localparam idx_t LAST = idx_t'(PKT_WORDS - 1);

    logic                             burst_on;
    idx_t                             widx, nxt;
    logic [PKT_WORDS-1:0][WORD_W-1:0] snap;
    lookup_t                          lk;
    logic                             last_word;

    assign nxt       = widx + 1'b1;
    assign lk        = find_slot(rx_hdr);
    assign last_word = word_done && burst_on && (widx == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_on <= 1'b0;
            widx     <= '0;
            snap     <= '0;
            tx_word  <= '0;
        end else if (word_done) begin
            if (burst_on) begin
                if (widx == LAST) begin
                    burst_on <= 1'b0;
                    widx     <= '0;
                    snap     <= sens;
                    tx_word  <= '0;
                end else begin
                    widx    <= nxt;
                    tx_word <= snap[nxt];
                end
            end else begin
                case (decode(rx_hdr))
                    CMD_BURST: begin
                        burst_on <= 1'b1;
                        widx     <= '0;
                        tx_word  <= snap[0];
                    end
                    CMD_POLL: tx_word <= lk.hit ? sens[lk.idx] : '0;
                    default:  tx_word <= '0;
                endcase
            end
        end
    end

    p_cmd_starts_r4: assert property (@(posedge clk) disable iff (rst)
        (word_done && !burst_on && rx_hdr == BURST_HDR) |=> (burst_on && widx == '0));
    p_burst_len_r4: assert property (@(posedge clk) disable iff (rst)
        last_word |=> !burst_on);
    p_stay_burst_r7: assert property (@(posedge clk) disable iff (rst)
        (burst_on && !last_word) |=> burst_on);
    p_snap_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !last_word |=> $stable(snap));
endmodule

// File: rtl/spibr_top.sv
module spibr_top
    import spibr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             spi_sclk,
    input  logic                             spi_cs_n,
    input  logic                             spi_mosi,
    output logic                             spi_miso,
    input  logic [PKT_WORDS-1:0][WORD_W-1:0] sens_words
);
    logic [2:0] pins_s;
    logic       word_done;
    hdr_t       rx_hdr;
    word_t      tx_word;

    spibr_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .INIT(3'b110)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({spi_sclk, spi_cs_n, spi_mosi}),
        .q   (pins_s)
    );

    spibr_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk      (pins_s[2]),
        .cs_n      (pins_s[1]),
        .mosi      (pins_s[0]),
        .tx_word   (tx_word),
        .miso      (spi_miso),
        .word_done (word_done),
        .rx_hdr    (rx_hdr)
    );

    spibr_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .word_done (word_done),
        .rx_hdr    (rx_hdr),
        .sens      (sens_words),
        .tx_word   (tx_word)
    );
endmodule

// File: tb/tb_spibr_top.sv
module tb_spibr_top;
    import spibr_pkg::*;

    localparam time CLK_PERIOD = 10ns;
    localparam int  HALF       = 8;
    localparam int  NPOLL      = 10;
    // {address, expected value with sensor set 1}
    localparam logic [23:0] POLL_VEC [NPOLL] = '{
        {8'h3C, 16'h1111}, {8'h04, 16'h2222}, {8'h06, 16'h3333}, {8'h08, 16'h4444},
        {8'h0A, 16'h5555}, {8'h0C, 16'h6666}, {8'h0E, 16'h7777}, {8'h18, 16'h8888},
        {8'h20, 16'h0000}, {8'h05, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b1, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [PKT_WORDS-1:0][WORD_W-1:0] sens = '0;
    int n_chk = 0, n_fail = 0;
    word_t r;

    always #(CLK_PERIOD/2) clk = ~clk;

    spibr_top dut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .sens_words(sens)
    );

    function automatic word_t val(input int set, input int k);
        case (set)
            1:       return word_t'(16'h1111 * (k + 1));
            2:       return word_t'(16'hB000 + k);
            3:       return word_t'(16'hC000 + k);
            default: return '0;
        endcase
    endfunction

    task automatic load(input int set);
        for (int k = 0; k < PKT_WORDS; k++) sens[k] = val(set, k);
    endtask

    task automatic chk(input string req, input word_t act, input word_t exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic sel(input bit low);
        repeat (4) @(negedge clk);
        cs_n = !low;
        repeat (4) @(negedge clk);
    endtask

    task automatic shift_word(input word_t tx, output word_t rx, input int nbits);
        for (int b = WORD_W - 1; b >= WORD_W - nbits; b--) begin
            @(negedge clk);
            sclk = 1'b0;
            mosi = tx[b];
            repeat (HALF) @(negedge clk);
            rx[b] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    task automatic xfer(input word_t tx, output word_t rx);
        sel(1);
        shift_word(tx, rx, WORD_W);
        sel(0);
    endtask

    task automatic burst(input int set, input bit held, input string req);
        word_t w;
        if (held) begin
            sel(1);
            shift_word(16'h3E00, w, WORD_W);
            for (int k = 0; k < PKT_WORDS; k++) begin
                shift_word(16'h0000, w, WORD_W);
                chk(req, w, val(set, k));
            end
            sel(0);
        end else begin
            xfer(16'h3E00, w);
            for (int k = 0; k < PKT_WORDS; k++) begin
                xfer(16'h0000, w);
                chk(req, w, val(set, k));
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        word_t tmp;
        load(1);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 miso after reset", word_t'(miso), '0);

        // R3: polled reads from the vector table
        for (int i = 0; i < NPOLL; i++) begin
            xfer({POLL_VEC[i][23:16], 8'h00}, r);
            xfer(16'h0000, r);
            chk("R3 polled read", r, POLL_VEC[i][15:0]);
        end

        // R2: partial word aborted by chip select is discarded
        xfer(16'h0600, r);
        sel(1);
        shift_word(16'h3E00, r, 5);
        sel(0);
        xfer(16'h0800, r);
        chk("R2 reply survives partial word", r, 16'h3333);
        xfer(16'h0000, r);
        chk("R2 no burst from partial word", r, 16'h4444);

        // R5/R1: first burst returns cleared snapshot
        burst(0, 1'b0, "R5 first burst stale");
        load(2);
        burst(1, 1'b0, "R4 R5 burst order toggled");
        burst(2, 1'b1, "R6 burst held select");

        // R8 / R9: polled read after burst
        load(3);
        xfer(16'h0400, r);
        chk("R9 word after burst end", r, 16'h0000);
        xfer(16'h0000, r);
        chk("R8 polled live value", r, val(3, 1));
        burst(2, 1'b0, "R8 snapshot untouched by poll");

        // R7: short burst, command word consumed as burst data
        xfer(16'h3E00, r);
        for (int k = 0; k < 4; k++) begin
            xfer(16'h0000, r);
            chk("R7 short burst data", r, val(3, k));
        end
        xfer(16'h0400, r);
        chk("R7 poll taken as burst word", r, val(3, 4));
        xfer(16'h0000, r);
        chk("R7 still in burst", r, val(3, 5));
        xfer(16'h0000, r);
        chk("R7 still in burst", r, val(3, 6));
        xfer(16'h0000, r);
        chk("R7 eighth word", r, val(3, 7));
        xfer(16'h0400, r);
        chk("R9 after burst end", r, 16'h0000);
        xfer(16'h0000, r);
        chk("R7 resync poll", r, val(3, 1));

        // R9: bit 15 set returns zero
        xfer(16'h8400, r);
        xfer(16'h0000, tmp);
        chk("R9 bit15 word", tmp, 16'h0000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule